// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block supplies the low-order address bits of a four-beat memory burst. On a cycle in which an address strobe is accepted, it captures the low bits of the external address as the start of a new burst. On later cycles it either moves one beat forward or keeps the current beat, depending on an advance input. The resulting bits are joined to the upper address, which is registered elsewhere, to form the full access address.

Two orders are supported, and the mode input chooses between them. In the interleaved order, each beat is the start value XORed with the beat index. In the linear order, each beat is the start value plus the beat index, wrapping modulo four. The block keeps the start value and a separate beat index, and it forms its output from the two. Mode is registered, so a change of mode reaches the output one clock after it is sampled. Strobe qualification takes three inputs: a processor strobe, a controller strobe and a chip-enable. The processor strobe counts only while the chip-enable is active.

Top module: `burst_addr_counter`

## Requirements
- R1: A synchronous active-high reset clears the start value and the beat index, so the output is 0 on the cycle after reset. The registered mode resets to linear.
- R2: When the controller strobe (adscN) is sampled low, the output on the next cycle equals the addrLow value sampled at that edge. This holds whatever the state of the processor strobe and the chip-enable.
- R3: When the processor strobe (adspN) is sampled low while ce1N is low, the output on the next cycle equals the sampled addrLow.
- R4: When ce1N is high, a low adspN is disregarded. With adscN high as well, the cycle behaves as though neither strobe were asserted, so advN alone decides between hold and advance.
- R5: When both strobes are low in the same cycle, the block performs a single load of addrLow. The burst restarts at beat 0.
- R6: Linear order (burstMode = 0): on each advance cycle the output increments by 1 modulo 4. From start 01 this gives 01, 10, 11, 00.
- R7: Interleaved order (burstMode = 1): beat k equals the start value XOR k. From start 01 this gives 01, 00, 11, 10.
- R8: With neither strobe accepted and advN high, the output holds its value (burst suspend).
- R9: After the fourth beat, a further advance wraps the beat index to 0 and the output returns to the start value. No error is signalled.
- R10: The output uses the burstMode value sampled at the previous clock edge. A change on burstMode leaves the output unchanged until the next rising edge.
- R11: A reset asserted in the middle of a burst returns the output to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addrLow | input | CNT_W | Low-order bits of the external address |
| adspN | input | 1 | Processor address strobe, active low, takes priority |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Advance, active low |
| ce1N | input | 1 | Chip-enable that qualifies the processor strobe, active low |
| burstMode | input | 1 | 1 selects interleaved order, 0 selects linear order |
| burstAddr | output | CNT_W | Current burst low-address bits |

## Verification
The bench builds the block with its default CNT_W of 2, which gives the four-beat burst. At this width every start value and every beat index can be reached, and the wrap needs only four advances. A behavioural model tracks the start value, the beat index and a delayed copy of the mode, and it is compared with the output after every clock. The directed sequences cover both orders from a non-zero start, strobe priority and the chip-enable masking, suspension, wrap, and the one-cycle mode latency. A seeded random sweep of all inputs follows.

// File: rtl/burst_cnt_pkg.sv
package burst_cnt_pkg;

  // Control word passed from the decode stage to the datapath
  typedef struct packed {
    logic load;        // capture a new start value, beat index to 0
    logic advance;     // step the beat index by one
    logic interleave;  // registered order select, 1 = XOR order
  } burstCtrl_t;

endpackage

// File: rtl/burst_cnt_ctrl.sv
module burst_cnt_ctrl
  import burst_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adspN,
  input  logic       adscN,
  input  logic       advN,
  input  logic       ce1N,
  input  logic       burstMode,
  output burstCtrl_t ctrl
);

  logic procStrobe;
  logic ctrlStrobe;
  logic modeQ;

  // The processor strobe is masked by the chip-enable
  assign procStrobe = ~adspN & ~ce1N;
  assign ctrlStrobe = ~adscN;

  // Mode takes effect one clock after it is sampled
  always_ff @(posedge clk) begin
    if (rst) modeQ <= 1'b0;
    else     modeQ <= burstMode;
  end

  always_comb begin
    ctrl.load       = procStrobe | ctrlStrobe;
    ctrl.advance    = ~procStrobe & ~ctrlStrobe & ~advN;
    ctrl.interleave = modeQ;
  end

endmodule

// File: rtl/burst_cnt_datapath.sv
module burst_cnt_datapath
  import burst_cnt_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  burstCtrl_t       ctrl,
  input  logic [CNT_W-1:0] addrLow,
  output logic [CNT_W-1:0] burstAddr
);

  logic [CNT_W-1:0] startQ;
  logic [CNT_W-1:0] stepQ;
  logic [CNT_W-1:0] xorAddr;
  logic [CNT_W-1:0] sumAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= '0;
      stepQ  <= '0;
    end else if (ctrl.load) begin
      startQ <= addrLow;
      stepQ  <= '0;
    end else if (ctrl.advance) begin
      stepQ  <= stepQ + CNT_W'(1);  // wraps after the last beat
    end
  end

  assign xorAddr   = startQ ^ stepQ;
  assign sumAddr   = startQ + stepQ;
  assign burstAddr = ctrl.interleave ? xorAddr : sumAddr;

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_cnt_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] addrLow,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             ce1N,
  input  logic             burstMode,
  output logic [CNT_W-1:0] burstAddr
);

  burstCtrl_t ctrlWord;

  burst_cnt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .adspN     (adspN),
    .adscN     (adscN),
    .advN      (advN),
    .ce1N      (ce1N),
    .burstMode (burstMode),
    .ctrl      (ctrlWord)
  );

  burst_cnt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrlWord),
    .addrLow   (addrLow),
    .burstAddr (burstAddr)
  );

endmodule

// File: rtl/burst_addr_counter_chk.sv
module burst_addr_counter_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] addrLow,
  input logic             adspN,
  input logic             adscN,
  input logic             advN,
  input logic             ce1N,
  input logic             burstMode,
  input logic [CNT_W-1:0] burstAddr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> burstAddr == '0);

  // R2
  load_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    !adscN |=> burstAddr == $past(addrLow));

  // R3
  load_proc_chk: assert property (@(posedge clk) disable iff (rst)
    (!adspN && !ce1N) |=> burstAddr == $past(addrLow));

  // R8
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adscN && (adspN || ce1N) && advN && $stable(burstMode) && !$past(rst))
      |=> $stable(burstAddr));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adscN && (adspN || ce1N) && !advN && !burstMode && $stable(burstMode) && !$past(rst))
      |=> burstAddr == CNT_W'($past(burstAddr) + CNT_W'(1)));

  // R1
  known_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(burstAddr));

endmodule

bind burst_addr_counter burst_addr_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addrLow   (addrLow),
  .adspN     (adspN),
  .adscN     (adscN),
  .advN      (advN),
  .ce1N      (ce1N),
  .burstMode (burstMode),
  .burstAddr (burstAddr)
);

// File: tb/burst_addr_counter_bench.sv
`timescale 1ns/1ps
module burst_addr_counter_bench;

  localparam int CNT_W = 2;
  localparam int BEATS = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] addrLow = '0;
  logic             adspN = 1'b1;
  logic             adscN = 1'b1;
  logic             advN = 1'b1;
  logic             ce1N = 1'b1;
  logic             burstMode = 1'b0;
  logic [CNT_W-1:0] burstAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int refStart = 0;
  int refStep = 0;
  int refMode = 0;

  always #5 clk = ~clk;

  burst_addr_counter #(.CNT_W(CNT_W)) u_burst_addr_counter (
    .clk(clk), .rst(rst), .addrLow(addrLow), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .burstMode(burstMode), .burstAddr(burstAddr)
  );

  function automatic int expected();
    if (refMode != 0) return refStart ^ refStep;
    return (refStart + refStep) % BEATS;
  endfunction

  task automatic check(string req, int exp);
    checks++;
    if (int'(burstAddr) !== exp) begin
      errors++;
      $display("FAIL %s: burstAddr=%0d expected=%0d at %0t", req, burstAddr, exp, $time);
    end
  endtask

  // Drive inputs at negedge, clock once, update the model, check at the next negedge
  task automatic cycle(string req, bit r, int a, bit sp, bit sc, bit av, bit ce, bit md);
    rst = r; addrLow = CNT_W'(a); adspN = sp; adscN = sc; advN = av; ce1N = ce; burstMode = md;
    @(posedge clk);
    if (r) begin
      refStart = 0; refStep = 0; refMode = 0;
    end else begin
      refMode = md;
      if (!sc || (!sp && !ce)) begin
        refStart = a; refStep = 0;
      end else if (!av) begin
        refStep = (refStep + 1) % BEATS;
      end
    end
    @(negedge clk);
    check(req, expected());
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    cycle("R1", 1, 3, 0, 0, 0, 0, 1);
    check("R1", 0);

    // R2 and R6: controller-strobe load, linear burst 01,10,11,00
    cycle("R2", 0, 1, 1, 0, 1, 1, 0);
    check("R2", 1);
    cycle("R6", 0, 0, 1, 1, 0, 1, 0); check("R6", 2);
    cycle("R6", 0, 0, 1, 1, 0, 1, 0); check("R6", 3);
    cycle("R6", 0, 0, 1, 1, 0, 1, 0); check("R6", 0);
    // R9: wrap back to the start value
    cycle("R9", 0, 0, 1, 1, 0, 1, 0); check("R9", 1);

    // R3 and R7: processor-strobe load, interleaved 01,00,11,10
    cycle("R3", 0, 1, 0, 1, 1, 0, 1); check("R3", 1);
    cycle("R7", 0, 2, 1, 1, 0, 0, 1); check("R7", 0);
    cycle("R7", 0, 2, 1, 1, 0, 0, 1); check("R7", 3);
    // R8: suspend holds
    cycle("R8", 0, 0, 1, 1, 1, 0, 1); check("R8", 3);
    cycle("R7", 0, 0, 1, 1, 0, 0, 1); check("R7", 2);
    cycle("R9", 0, 0, 1, 1, 0, 0, 1); check("R9", 1);

    // R4: processor strobe masked by ce1N, advN decides
    cycle("R4", 0, 3, 0, 1, 1, 1, 1); check("R4", 1);
    cycle("R4", 0, 3, 0, 1, 0, 1, 1); check("R4", 0);

    // R5: both strobes low give a single load
    cycle("R5", 0, 2, 0, 0, 0, 0, 0); check("R5", 2);
    // R2: controller strobe loads even when processor strobe is masked
    cycle("R2", 0, 3, 0, 0, 0, 1, 0); check("R2", 3);

    // R10: mode change shows only after the next edge
    cycle("R10", 0, 1, 1, 0, 1, 1, 0); check("R10", 1);
    cycle("R10", 0, 0, 1, 1, 0, 1, 0); check("R10", 2);
    burstMode = 1'b1; #1;
    check("R10", 2);
    cycle("R10", 0, 0, 1, 1, 1, 1, 1); check("R10", 0);

    // R11: reset in mid-burst
    cycle("R11", 0, 0, 1, 1, 0, 1, 1);
    cycle("R11", 1, 2, 1, 1, 0, 1, 1); check("R11", 0);

    // random sweep against the model
    for (int i = 0; i < 2000; i++) begin
      cycle("R8", ($urandom % 50) == 0, $urandom % BEATS, $urandom % 4 == 0,
            $urandom % 4 == 0, $urandom % 2, $urandom % 2, $urandom % 8 == 0 ? ~burstMode : burstMode);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule